// File: doc/BRIEF.md
# E1-to-T1 Channel Mapper

This block takes the bytes of a 32-timeslot, 2.048 Mb/s system frame, one byte per accepted cycle together with its timeslot number, and decides for each byte whether it becomes one of the 24 channels of a 193-bit T1 line frame or is dropped. Timeslot 0 does not carry payload. One bit of that byte becomes the T1 framing bit, and the other seven bits are thrown away.

A 2-bit mode input picks one of three maps: a fixed split table, a filler map that drops every fourth timeslot, and a continuous map. The mode is taken only when a timeslot 0 byte arrives, so a frame is never mapped under two schemes. Each kept byte appears one cycle later with its channel number. A strobe marks the byte that fills channel 24, and a one-cycle error pulse marks a new frame that starts before the previous frame has produced all 24 channels. Rate adaptation and signalling are handled elsewhere.

Top module: `ts_to_t1_mapper`

## Requirements
- R1: Every output pulse comes exactly one clock after the accepted input byte that caused it. `ch_byte` equals that input byte unchanged.
- R2: With the active mode 2'b10, or with the reserved value 2'b11, timeslots 1 to 24 become channels 1 to 24 in order, and timeslots 25 to 31 are dropped.
- R3: With the active mode 2'b01, every timeslot whose number is a multiple of four (4, 8, ..., 28) is dropped. The remaining timeslots 1 to 31 become channels 1 to 24 in order, so timeslot 5 gives channel 4 and timeslot 31 gives channel 24.
- R4: With the active mode 2'b00, timeslots 1 to 12 become channels 1 to 12 and timeslots 17 to 28 become channels 13 to 24. Timeslots 13 to 16 and 29 to 31 are dropped.
- R5: A timeslot 0 byte gives `fbit_valid` high for one cycle, with `fbit` equal to bit 0 of that byte (the eighth bit sent, most significant bit first). It never gives a channel output.
- R6: `mode_sel` is sampled only when a timeslot 0 byte is accepted. A change during a frame affects only the following frames. After reset the active mode is 2'b00.
- R7: `frame_done` is high in exactly the cycle in which channel 24 is presented on the channel outputs.
- R8: `short_err` pulses together with `fbit_valid` when a timeslot 0 byte arrives and the frame before it produced a number of channels other than 24. It stays low on the first timeslot 0 after reset.
- R9: During reset and in the first cycle after it, every output is low.
- R10: A cycle with `in_valid` low produces no output pulse, whatever `in_ts` and `in_byte` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Requested map: 00 split, 01 filler, 10/11 continuous |
| in_valid | input | 1 | Input byte is present this cycle |
| in_ts | input | 5 | Timeslot number of the input byte |
| in_byte | input | 8 | Timeslot byte |
| fbit_valid | output | 1 | Framing bit is present |
| fbit | output | 1 | T1 framing bit |
| ch_valid | output | 1 | Channel byte is present |
| ch_idx | output | 5 | Channel number, 1 to 24 |
| ch_byte | output | 8 | Channel byte |
| frame_done | output | 1 | Channel 24 is being presented |
| short_err | output | 1 | The frame just ended had other than 24 channels |

## Verification
The hardest situation to reach is a mode change in the middle of a frame. From the ports it looks the same as a correct change, unless the bench later sends a timeslot that both maps give, but to different channels. The bench runs a continuous frame, switches `mode_sel` to filler at timeslot 9, and then sends timeslot 10. That byte must still come out as channel 10 and not channel 8. After the next timeslot 0, the same timeslot must come out as channel 8. Short frames, which follow a frame that stopped early, are produced by sending timeslot 0 after only a few payload timeslots.

// File: rtl/t1map_pkg.sv
// Package: shared widths, map mode encoding and the per-timeslot map rule.
// Assumes timeslot numbers 0..31 and a 24-channel line frame.
package t1map_pkg;

    localparam int TS_W     = 5;
    localparam int BYTE_W   = 8;
    localparam int CH_W     = 5;
    localparam int NUM_CH   = 24;

    typedef enum logic [1:0] {
        MAP_SPLIT  = 2'b00,
        MAP_FILLER = 2'b01,
        MAP_CONT   = 2'b10,
        MAP_RSVD   = 2'b11
    } map_mode_e;

    typedef struct packed {
        logic            keep;
        logic [CH_W-1:0] ch;
    } map_res_t;

    // Channel number for one timeslot under one map; keep=0 means dropped.
    function automatic map_res_t map_slot(input map_mode_e m, input logic [TS_W-1:0] ts);
        map_res_t r;
        r.keep = 1'b0;
        r.ch   = '0;
        case (m)
            MAP_SPLIT: begin
                if (ts >= 5'd1 && ts <= 5'd12) begin
                    r.keep = 1'b1;
                    r.ch   = ts;
                end else if (ts >= 5'd17 && ts <= 5'd28) begin
                    r.keep = 1'b1;
                    r.ch   = ts - 5'd4;
                end
            end
            MAP_FILLER: begin
                if (ts != '0 && ts[1:0] != 2'b00) begin
                    r.keep = 1'b1;
                    r.ch   = ts - {2'b00, ts[4:2]};
                end
            end
            default: begin
                if (ts >= 5'd1 && ts <= 5'd24) begin
                    r.keep = 1'b1;
                    r.ch   = ts;
                end
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/t1map_classifier.sv
// Module: t1map_classifier
// Decides, for the byte now at the input, if it is the framing slot, a kept
// channel (with its channel number), or a dropped timeslot.
// Assumes the mode given is the one latched for the current frame.
module t1map_classifier
    import t1map_pkg::*;
#(
    parameter int P_TS_W = TS_W,
    parameter int P_CH_W = CH_W
) (
    input  map_mode_e         mode,
    input  logic              in_valid,
    input  logic [P_TS_W-1:0] in_ts,
    output logic              is_fslot,
    output logic              keep,
    output logic [P_CH_W-1:0] ch
);

    map_res_t res;

    // Look up the map and qualify with input valid.
    always_comb begin
        res      = map_slot(mode, in_ts);
        is_fslot = in_valid && (in_ts == '0);
        keep     = in_valid && res.keep;
        ch       = res.ch;
    end

endmodule

// File: rtl/t1map_frame_tracker.sv
// Module: t1map_frame_tracker
// Holds the mode active for the current frame, counts channels emitted in it,
// and flags a new frame that starts before a full set of channels was seen.
// Assumes timeslot 0 marks the start of each frame.
module t1map_frame_tracker
    import t1map_pkg::*;
#(
    parameter int P_NUM_CH = NUM_CH,
    localparam int CNT_W   = $clog2(P_NUM_CH + 1) + 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic [1:0] mode_sel,
    input  logic      is_fslot,
    input  logic      keep,
    output map_mode_e active_mode,
    output logic      short_now
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(P_NUM_CH);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [CNT_W-1:0] ch_cnt;
    logic             seen_frame;

    // Latch the requested mode at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)        active_mode <= MAP_SPLIT;
        else if (is_fslot) active_mode <= map_mode_e'(mode_sel);
    end

    // Count kept channels in the current frame, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ch_cnt <= '0;
        else if (is_fslot)                ch_cnt <= '0;
        else if (keep && ch_cnt != CNT_MAX) ch_cnt <= ch_cnt + 1'b1;
    end

    // Remember that at least one frame start has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n)        seen_frame <= 1'b0;
        else if (is_fslot) seen_frame <= 1'b1;
    end

    // Frame start after an incomplete (or overfull) frame.
    always_comb short_now = is_fslot && seen_frame && (ch_cnt != CNT_FULL);

endmodule

// File: rtl/t1map_out_stage.sv
// Module: t1map_out_stage
// Output register stage: presents framing bit, channel byte and strobes one
// cycle after the input byte. Assumes at most one input byte per cycle.
module t1map_out_stage
    import t1map_pkg::*;
#(
    parameter int P_BYTE_W = BYTE_W,
    parameter int P_CH_W   = CH_W,
    parameter int P_NUM_CH = NUM_CH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                is_fslot,
    input  logic                keep,
    input  logic [P_CH_W-1:0]   ch,
    input  logic [P_BYTE_W-1:0] in_byte,
    input  logic                short_now,
    output logic                fbit_valid,
    output logic                fbit,
    output logic                ch_valid,
    output logic [P_CH_W-1:0]   ch_idx,
    output logic [P_BYTE_W-1:0] ch_byte,
    output logic                frame_done,
    output logic                short_err
);

    localparam logic [P_CH_W-1:0] LAST_CH = P_CH_W'(P_NUM_CH);

    // Framing bit path: the last-sent bit of timeslot 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fbit_valid <= 1'b0;
            fbit       <= 1'b0;
            short_err  <= 1'b0;
        end else begin
            fbit_valid <= is_fslot;
            fbit       <= is_fslot ? in_byte[0] : 1'b0;
            short_err  <= short_now;
        end
    end

    // Channel path: kept byte with its channel number and end-of-frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_valid   <= 1'b0;
            ch_idx     <= '0;
            ch_byte    <= '0;
            frame_done <= 1'b0;
        end else begin
            ch_valid   <= keep;
            ch_idx     <= keep ? ch : '0;
            ch_byte    <= keep ? in_byte : '0;
            frame_done <= keep && (ch == LAST_CH);
        end
    end

endmodule

// File: rtl/ts_to_t1_mapper.sv
// Module: ts_to_t1_mapper (top)
// Maps 32-timeslot system frame bytes onto 24 T1 channels plus framing bit
// under a mode chosen at each frame start. Assumes one byte per valid cycle
// and timeslot 0 opening each frame.
module ts_to_t1_mapper
    import t1map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              in_valid,
    input  logic [TS_W-1:0]   in_ts,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              fbit_valid,
    output logic              fbit,
    output logic              ch_valid,
    output logic [CH_W-1:0]   ch_idx,
    output logic [BYTE_W-1:0] ch_byte,
    output logic              frame_done,
    output logic              short_err
);

    map_mode_e       active_mode;
    logic            is_fslot;
    logic            keep;
    logic [CH_W-1:0] ch;
    logic            short_now;

    t1map_classifier #(.P_TS_W(TS_W), .P_CH_W(CH_W)) u_cls (
        .mode     (active_mode),
        .in_valid (in_valid),
        .in_ts    (in_ts),
        .is_fslot (is_fslot),
        .keep     (keep),
        .ch       (ch)
    );

    t1map_frame_tracker #(.P_NUM_CH(NUM_CH)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .is_fslot    (is_fslot),
        .keep        (keep),
        .active_mode (active_mode),
        .short_now   (short_now)
    );

    t1map_out_stage #(.P_BYTE_W(BYTE_W), .P_CH_W(CH_W), .P_NUM_CH(NUM_CH)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_fslot   (is_fslot),
        .keep       (keep),
        .ch         (ch),
        .in_byte    (in_byte),
        .short_now  (short_now),
        .fbit_valid (fbit_valid),
        .fbit       (fbit),
        .ch_valid   (ch_valid),
        .ch_idx     (ch_idx),
        .ch_byte    (ch_byte),
        .frame_done (frame_done),
        .short_err  (short_err)
    );

endmodule

// File: rtl/ts_to_t1_mapper_chk.sv
// Module: ts_to_t1_mapper_chk
// Port-level properties of the mapper, bound to every instance of the top.
module ts_to_t1_mapper_chk
    import t1map_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [TS_W-1:0]   in_ts,
    input logic [BYTE_W-1:0] in_byte,
    input logic              fbit_valid,
    input logic              fbit,
    input logic              ch_valid,
    input logic [CH_W-1:0]   ch_idx,
    input logic [BYTE_W-1:0] ch_byte,
    input logic              frame_done,
    input logic              short_err
);

    // R1, R10: a channel pulse needs an accepted input byte one cycle before
    a_r10_no_input_no_ch: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> $past(in_valid));

    // R1: the channel byte is the input byte unchanged
    a_r1_byte_passes: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> ch_byte == $past(in_byte));

    // R2, R3, R4: channel numbers stay in 1..24
    a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> (ch_idx >= 5'd1 && ch_idx <= 5'd24));

    // R5: framing bit follows a timeslot 0 byte, from its bit 0
    a_r5_fbit_from_ts0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(in_ts) == '0)
            |-> (fbit_valid && fbit == $past(in_byte[0]) && !ch_valid));

    // R7: done strobe only with channel 24
    a_r7_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (ch_valid && ch_idx == 5'd24));

    // R8: error pulse only at a frame start
    a_r8_err_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        short_err |-> fbit_valid);

    // R9: outputs low in the first cycle after reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        ($past(rst_n) == 1'b0) |-> !(fbit_valid || ch_valid || frame_done || short_err));

endmodule

bind ts_to_t1_mapper ts_to_t1_mapper_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ts      (in_ts),
    .in_byte    (in_byte),
    .fbit_valid (fbit_valid),
    .fbit       (fbit),
    .ch_valid   (ch_valid),
    .ch_idx     (ch_idx),
    .ch_byte    (ch_byte),
    .frame_done (frame_done),
    .short_err  (short_err)
);

// File: tb/ts_to_t1_mapper_tb.sv
module ts_to_t1_mapper_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       in_valid = 1'b0;
    logic [4:0] in_ts = '0;
    logic [7:0] in_byte = '0;
    logic       fbit_valid, fbit, ch_valid, frame_done, short_err;
    logic [4:0] ch_idx;
    logic [7:0] ch_byte;

    int total = 0;
    int bad   = 0;

    // Captured outputs after each transfer
    logic       o_fv, o_fb, o_cv, o_fd, o_se;
    logic [4:0] o_ci;
    logic [7:0] o_cb;

    always #2 clk = ~clk;

    ts_to_t1_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
        .in_ts(in_ts), .in_byte(in_byte), .fbit_valid(fbit_valid), .fbit(fbit),
        .ch_valid(ch_valid), .ch_idx(ch_idx), .ch_byte(ch_byte),
        .frame_done(frame_done), .short_err(short_err)
    );

    // Vector: {mode[12:11], ts[10:6], keep[5], channel[4:0]}
    localparam int NV = 18;
    localparam logic [12:0] VEC [NV] = '{
        {2'd2, 5'd1,  1'b1, 5'd1 },
        {2'd2, 5'd24, 1'b1, 5'd24},
        {2'd2, 5'd25, 1'b0, 5'd0 },
        {2'd2, 5'd31, 1'b0, 5'd0 },
        {2'd1, 5'd1,  1'b1, 5'd1 },
        {2'd1, 5'd3,  1'b1, 5'd3 },
        {2'd1, 5'd4,  1'b0, 5'd0 },
        {2'd1, 5'd5,  1'b1, 5'd4 },
        {2'd1, 5'd28, 1'b0, 5'd0 },
        {2'd1, 5'd29, 1'b1, 5'd22},
        {2'd1, 5'd31, 1'b1, 5'd24},
        {2'd0, 5'd12, 1'b1, 5'd12},
        {2'd0, 5'd13, 1'b0, 5'd0 },
        {2'd0, 5'd16, 1'b0, 5'd0 },
        {2'd0, 5'd17, 1'b1, 5'd13},
        {2'd0, 5'd28, 1'b1, 5'd24},
        {2'd0, 5'd29, 1'b0, 5'd0 },
        {2'd3, 5'd24, 1'b1, 5'd24}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one byte (or idle when v=0), capture outputs one clock later.
    task automatic xfer(input bit v, input logic [4:0] ts, input logic [7:0] b);
        in_valid = v; in_ts = ts; in_byte = b;
        @(negedge clk);
        o_fv = fbit_valid; o_fb = fbit; o_cv = ch_valid; o_ci = ch_idx;
        o_cb = ch_byte; o_fd = frame_done; o_se = short_err;
        in_valid = 1'b0;
    endtask

    // Reference: count timeslots kept up to ts under the mode rule.
    function automatic int ref_ch(input logic [1:0] m, input int ts);
        int n = 0;
        bit k = 1'b0;
        for (int t = 1; t <= ts; t++) begin
            case (m)
                2'd0:    k = (t <= 12) || (t >= 17 && t <= 28);
                2'd1:    k = (t % 4) != 0;
                default: k = t <= 24;
            endcase
            if (k) n++;
        end
        return k ? n : 0;
    endfunction

    // One full frame under mode m; checks each output.
    task automatic full_frame(input logic [1:0] m, input string req);
        int cnt = 0;
        int dn  = 0;
        mode_sel = m;
        xfer(1'b1, 5'd0, 8'h00);
        for (int t = 1; t < 32; t++) begin
            int e;
            e = ref_ch(m, t);
            xfer(1'b1, 5'(t), 8'(t * 7 + 3));
            check(o_cv == (e != 0) && (e == 0 || (o_ci == 5'(e) && o_cb == 8'(t * 7 + 3))),
                  req, o_cv ? int'(o_ci) : 0, e);
            if (o_cv) cnt++;
            if (o_fd) dn++;
        end
        check(cnt == 24, req, cnt, 24);
        check(dn == 1, "R7", dn, 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9: outputs low during reset even with input activity
        in_valid = 1'b1; in_ts = 5'd0; in_byte = 8'hFF;
        @(negedge clk);
        check(!(fbit_valid || ch_valid || frame_done || short_err), "R9",
              int'({fbit_valid, ch_valid, frame_done, short_err}), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!(fbit_valid || ch_valid || frame_done || short_err), "R9",
              int'({fbit_valid, ch_valid, frame_done, short_err}), 0);

        // R6: reset mode is split: TS13 dropped, TS17 gives CH13 before any TS0
        mode_sel = 2'd2;
        xfer(1'b1, 5'd13, 8'h11);
        check(!o_cv, "R6", int'(o_cv), 0);
        xfer(1'b1, 5'd17, 8'h22);
        check(o_cv && o_ci == 5'd13, "R6", int'(o_ci), 13);

        // Vector table walk: R2 R3 R4 R5 R7
        for (int i = 0; i < NV; i++) begin
            logic [1:0] vm; logic [4:0] vt; logic vk; logic [4:0] vc;
            {vm, vt, vk, vc} = VEC[i];
            mode_sel = vm;
            xfer(1'b1, 5'd0, 8'(i));
            check(o_fv && o_fb == i[0] && !o_cv, "R5", int'(o_fb), i % 2);
            xfer(1'b1, vt, 8'hA0 + 8'(i));
            check(o_cv == vk && (!vk || (o_ci == vc && o_cb == 8'hA0 + 8'(i))),
                  vm == 2'd0 ? "R4" : (vm == 2'd1 ? "R3" : "R2"),
                  o_cv ? int'(o_ci) : 0, vk ? int'(vc) : 0);
            check(o_fd == (vk && vc == 5'd24), "R7", int'(o_fd), int'(vk && vc == 5'd24));
        end

        // Full frames in each mode; R8 error at TS0 after a complete frame is low
        full_frame(2'd2, "R2");
        full_frame(2'd1, "R3");
        full_frame(2'd0, "R4");
        full_frame(2'd3, "R2");
        mode_sel = 2'd2;
        xfer(1'b1, 5'd0, 8'h01);
        check(o_fv && o_fb && !o_se, "R8", int'(o_se), 0);

        // R6: mid-frame change has no effect until next TS0
        for (int t = 1; t < 10; t++) xfer(1'b1, 5'(t), 8'h00);
        mode_sel = 2'd1;
        xfer(1'b1, 5'd10, 8'h5A);
        check(o_cv && o_ci == 5'd10, "R6", int'(o_ci), 10);
        xfer(1'b1, 5'd0, 8'h00);
        check(o_se, "R8", int'(o_se), 1);
        xfer(1'b1, 5'd10, 8'h5B);
        check(o_cv && o_ci == 5'd8, "R6", int'(o_ci), 8);

        // R10: idle cycles with channel-like values produce nothing
        xfer(1'b0, 5'd24, 8'hFF);
        check(!(o_cv || o_fv || o_fd), "R10", int'({o_cv, o_fv, o_fd}), 0);
        xfer(1'b0, 5'd0, 8'hFF);
        check(!(o_cv || o_fv || o_se), "R10", int'({o_cv, o_fv, o_se}), 0);

        // R1: output one cycle late, gone the next idle cycle
        xfer(1'b1, 5'd31, 8'hC3);
        check(o_cv && o_cb == 8'hC3, "R1", int'(o_cb), 195);
        xfer(1'b0, 5'd0, 8'h00);
        check(!o_cv, "R1", int'(o_cv), 0);

        // R8: reset, then first TS0 has no error even after a short start
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        xfer(1'b1, 5'd1, 8'h00);
        xfer(1'b1, 5'd0, 8'h00);
        check(o_fv && !o_se, "R8", int'(o_se), 0);
        xfer(1'b1, 5'd1, 8'h00);
        xfer(1'b1, 5'd2, 8'h00);
        xfer(1'b1, 5'd0, 8'h00);
        check(o_se, "R8", int'(o_se), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule